// File: doc/BRIEF.md
# Burst-of-Two Separate-I/O Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static memory that has a separate write data input and read data output. Each access moves a fixed pair of words. It is modelled as single-clock logic that runs at the beat rate, so one clock cycle stands for one half-cycle of a double-data-rate interface. Reads and writes each have their own active-low command strobe and their own word-pair address. The two ports run independently, so one read burst and one write burst can overlap.

The external address selects a pair of words. The block appends the low address bit itself: 0 on the first beat and 1 on the second. Each write beat carries its own byte enables. Read data goes through a two-stage output pipeline. A bypass path makes reads see writes that have been sampled but not yet committed to the array. An echo clock output toggles every cycle, and a valid flag marks the cycles that carry read data.

Top module: `b2s_sram`

## Requirements
- R1: A command on either port that is accepted moves exactly two data beats. A read gives two consecutive cycles with `rvalid` high, and a write stores two words.
- R2: The internal word index is `{addr, lsb}`, with lsb 0 on the first beat and 1 on the second. Read beat 0 returns word 2·addr and beat 1 returns word 2·addr+1. A write stores data beat 0 into word 2·addr and data beat 1 into word 2·addr+1.
- R3: While `rd_n` and `wr_n` are both high and no burst is running, no transfer starts. `rvalid` stays low and no memory word changes.
- R4: A command on a port during the first beat of that port's running burst is ignored. A command during the second beat is accepted, which gives gapless back-to-back bursts.
- R5: The read and write ports are independent. A command on one port never alters or delays a burst on the other port.
- R6: A read command sampled at clock edge k puts beat 0 on `rdata` after edge k+2 and beat 1 after edge k+3, with `rvalid` high in exactly those two cycles. A write command sampled at edge k takes its data beat 0 at edge k+1 and its data beat 1 at edge k+2.
- R7: `wbe[i]` (active high) enables bits [9i+8:9i] of the word. Enables are sampled together with each data beat. A byte whose enable is 0 keeps its old value. Enables and data present in the write command cycle are ignored.
- R8: Read beat n (n = 0, 1) of a read command sampled at edge k reflects every write beat sampled at edge k+n or earlier, including beats not yet committed to the array.
- R9: `echo_clk` is 0 in reset and inverts on every clock edge after reset.
- R10: During reset `rvalid` is 0 and no burst is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_n | input | 1 | Read command strobe, active low |
| rd_addr | input | AW | Word-pair address of the read |
| wr_n | input | 1 | Write command strobe, active low |
| wr_addr | input | AW | Word-pair address of the write |
| wdata | input | DW | Write data beat |
| wbe | input | NB | Byte enables for the write data beat, active high |
| rdata | output | DW | Read data beat |
| rvalid | output | 1 | High in the cycles that carry read data |
| echo_clk | output | 1 | Echo clock, toggles every cycle |

## Verification
The case hardest to reach from the ports is a read that catches a write beat sitting in the pending stage, sampled but not yet in the array. The stimulus issues a write command and then a read of the same pair exactly one edge later, with complementary partial byte masks. Both read beats then have to come through the bypass merge. A second scenario issues both commands on the same edge, where both beats must return the old contents. Together the two scenarios pin down the coherence boundary from both sides.

// File: rtl/b2s_pkg.sv
package b2s_pkg;
    typedef enum logic [1:0] {
        BT_IDLE   = 2'd0,
        BT_FIRST  = 2'd1,
        BT_SECOND = 2'd2
    } beat_e;
endpackage

// File: rtl/b2s_burst_seq.sv
module b2s_burst_seq
    import b2s_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_n,
    input  logic [AW-1:0] cmd_addr,
    output logic          beat_v,
    output logic [AW:0]   beat_addr
);
    typedef struct packed {
        beat_e         st;
        logic [AW-1:0] base;
    } seq_t;

    seq_t seq_d, seq_q;
    logic accept;

    always_comb begin
        seq_d  = seq_q;
        accept = !cmd_n && (seq_q.st != BT_FIRST);
        if (accept) begin
            seq_d.st   = BT_FIRST;
            seq_d.base = cmd_addr;
        end else if (seq_q.st == BT_FIRST) begin
            seq_d.st = BT_SECOND;
        end else begin
            seq_d.st = BT_IDLE;
        end
        beat_v    = (seq_q.st != BT_IDLE);
        beat_addr = {seq_q.base, (seq_q.st == BT_SECOND)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: BT_IDLE, base: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    // R4
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == BT_FIRST) |=> (seq_q.st == BT_SECOND && $stable(seq_q.base)));
endmodule

// File: rtl/b2s_wpipe.sv
module b2s_wpipe #(
    parameter int IW = 7,
    parameter int DW = 36,
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          beat_v,
    input  logic [IW-1:0] beat_addr,
    input  logic [DW-1:0] wdata,
    input  logic [NB-1:0] wbe,
    output logic          pend_v,
    output logic [IW-1:0] pend_addr,
    output logic [DW-1:0] pend_data,
    output logic [NB-1:0] pend_be
);
    typedef struct packed {
        logic          v;
        logic [IW-1:0] addr;
        logic [DW-1:0] data;
        logic [NB-1:0] be;
    } pend_t;

    pend_t pd_d, pd_q;

    always_comb begin
        pd_d   = pd_q;
        pd_d.v = beat_v;
        if (beat_v) begin
            pd_d.addr = beat_addr;
            pd_d.data = wdata;
            pd_d.be   = wbe;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd_q <= '0;
        end else begin
            pd_q <= pd_d;
        end
    end

    assign pend_v    = pd_q.v;
    assign pend_addr = pd_q.addr;
    assign pend_data = pd_q.data;
    assign pend_be   = pd_q.be;
endmodule

// File: rtl/b2s_array.sv
module b2s_array #(
    parameter int IW = 7,
    parameter int DW = 36,
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pend_v,
    input  logic [IW-1:0] pend_addr,
    input  logic [DW-1:0] pend_data,
    input  logic [NB-1:0] pend_be,
    input  logic          rd_v,
    input  logic [IW-1:0] rd_addr,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    localparam int BW    = DW / NB;
    localparam int DEPTH = 1 << IW;

    typedef struct packed {
        logic          s1_v;
        logic [DW-1:0] s1_data;
        logic          out_v;
        logic [DW-1:0] out_data;
    } rpipe_t;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] raw_word;
    logic [DW-1:0] merged;
    logic          hit;
    rpipe_t        rp_d, rp_q;

    assign raw_word = mem[rd_addr];
    assign hit      = pend_v && (pend_addr == rd_addr);

    for (genvar b = 0; b < NB; b++) begin : g_merge
        assign merged[b*BW +: BW] = (hit && pend_be[b]) ? pend_data[b*BW +: BW]
                                                        : raw_word[b*BW +: BW];
    end

    always_ff @(posedge clk) begin
        if (pend_v) begin
            for (int b = 0; b < NB; b++) begin
                if (pend_be[b]) begin
                    mem[pend_addr][b*BW +: BW] <= pend_data[b*BW +: BW];
                end
            end
        end
    end

    always_comb begin
        rp_d          = rp_q;
        rp_d.s1_v     = rd_v;
        rp_d.s1_data  = rd_v ? merged : rp_q.s1_data;
        rp_d.out_v    = rp_q.s1_v;
        rp_d.out_data = rp_q.s1_v ? rp_q.s1_data : rp_q.out_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rp_q <= '0;
        end else begin
            rp_q <= rp_d;
        end
    end

    assign rdata  = rp_q.out_data;
    assign rvalid = rp_q.out_v;

    // R7
    byte_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_v && pend_be[0]) |=> (mem[$past(pend_addr)][BW-1:0] == $past(pend_data[BW-1:0])));
endmodule

// File: rtl/b2s_sram.sv
module b2s_sram #(
    parameter int AW = 6,
    parameter int DW = 36,
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_n,
    input  logic [AW-1:0] rd_addr,
    input  logic          wr_n,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wdata,
    input  logic [NB-1:0] wbe,
    output logic [DW-1:0] rdata,
    output logic          rvalid,
    output logic          echo_clk
);
    localparam int IW = AW + 1;

    logic          rd_bv, wr_bv;
    logic [IW-1:0] rd_ia, wr_ia;
    logic          pend_v;
    logic [IW-1:0] pend_addr;
    logic [DW-1:0] pend_data;
    logic [NB-1:0] pend_be;
    logic          echo_d, echo_q;

    b2s_burst_seq #(.AW(AW)) u_rd_seq (
        .clk(clk), .rst_n(rst_n), .cmd_n(rd_n), .cmd_addr(rd_addr),
        .beat_v(rd_bv), .beat_addr(rd_ia)
    );

    b2s_burst_seq #(.AW(AW)) u_wr_seq (
        .clk(clk), .rst_n(rst_n), .cmd_n(wr_n), .cmd_addr(wr_addr),
        .beat_v(wr_bv), .beat_addr(wr_ia)
    );

    b2s_wpipe #(.IW(IW), .DW(DW), .NB(NB)) u_wpipe (
        .clk(clk), .rst_n(rst_n), .beat_v(wr_bv), .beat_addr(wr_ia),
        .wdata(wdata), .wbe(wbe), .pend_v(pend_v), .pend_addr(pend_addr),
        .pend_data(pend_data), .pend_be(pend_be)
    );

    b2s_array #(.IW(IW), .DW(DW), .NB(NB)) u_array (
        .clk(clk), .rst_n(rst_n), .pend_v(pend_v), .pend_addr(pend_addr),
        .pend_data(pend_data), .pend_be(pend_be), .rd_v(rd_bv), .rd_addr(rd_ia),
        .rdata(rdata), .rvalid(rvalid)
    );

    always_comb echo_d = ~echo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) echo_q <= 1'b0;
        else        echo_q <= echo_d;
    end

    assign echo_clk = echo_q;

    // R6
    rvalid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_bv |=> ##1 rvalid);

    // R2
    lsb_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_bv && rd_ia[0]) |-> ($past(rd_bv) && !$past(rd_ia[0])
                                 && ($past(rd_ia[IW-1:1]) == rd_ia[IW-1:1])));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n && !rd_bv) |=> !rd_bv);

    // R9
    echo_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (echo_clk != $past(echo_clk)));
endmodule

// File: tb/sim_b2s_sram.sv
module sim_b2s_sram;
    localparam int AW = 6;
    localparam int DW = 36;
    localparam int NB = 4;
    localparam int NW = 1 << (AW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_n = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic          wr_n = 1'b1;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [NB-1:0] wbe = '0;
    logic [DW-1:0] rdata;
    logic          rvalid;
    logic          echo_clk;

    int nchk  = 0;
    int nfail = 0;
    logic [DW-1:0] model [NW];

    always #2.5 clk = ~clk;

    b2s_sram #(.AW(AW), .DW(DW), .NB(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .rd_addr(rd_addr),
        .wr_n(wr_n), .wr_addr(wr_addr), .wdata(wdata), .wbe(wbe),
        .rdata(rdata), .rvalid(rvalid), .echo_clk(echo_clk)
    );

    function automatic logic [DW-1:0] pat(input int i, input int salt);
        logic [15:0] lo = i[15:0];
        logic [3:0]  s  = salt[3:0];
        return {lo ^ 16'h3C5A, s, lo * 16'd97} ^ 36'h5A5A5A5A5;
    endfunction

    function automatic logic [DW-1:0] mrg(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                          input logic [NB-1:0] be);
        logic [DW-1:0] r = old;
        for (int b = 0; b < NB; b++) if (be[b]) r[b*9 +: 9] = nw[b*9 +: 9];
        return r;
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic rn, input logic [AW-1:0] ra, input logic wn,
                       input logic [AW-1:0] wa, input logic [DW-1:0] wd, input logic [NB-1:0] be);
        rd_n = rn; rd_addr = ra; wr_n = wn; wr_addr = wa; wdata = wd; wbe = be;
        @(negedge clk);
    endtask

    task automatic idle();
        cyc(1'b1, '0, 1'b1, '0, '0, '0);
    endtask

    // Command cycle carries junk data with all enables set: must be ignored (R7)
    task automatic wr_burst(input logic [AW-1:0] a, input logic [DW-1:0] d0, input logic [NB-1:0] b0,
                            input logic [DW-1:0] d1, input logic [NB-1:0] b1);
        cyc(1'b1, '0, 1'b0, a, ~d0, '1);
        cyc(1'b1, '0, 1'b1, '0, d0, b0);
        cyc(1'b1, '0, 1'b1, '0, d1, b1);
        model[{a, 1'b0}] = mrg(model[{a, 1'b0}], d0, b0);
        model[{a, 1'b1}] = mrg(model[{a, 1'b1}], d1, b1);
    endtask

    task automatic rd_burst(input logic [AW-1:0] a, input string req);
        cyc(1'b0, a, 1'b1, '0, '0, '0);
        idle();
        idle();
        chk({req, " R6 valid beat0"}, {35'b0, rvalid}, 36'd1);
        chk({req, " R2 beat0"}, rdata, model[{a, 1'b0}]);
        idle();
        chk({req, " R1 valid beat1"}, {35'b0, rvalid}, 36'd1);
        chk({req, " R2 beat1"}, rdata, model[{a, 1'b1}]);
        idle();
        chk({req, " R1 two beats only"}, {35'b0, rvalid}, 36'd0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic prev;
        logic [DW-1:0] o0, o1, n0, n1;
        for (int i = 0; i < NW; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 rvalid in reset", {35'b0, rvalid}, 36'd0);
        chk("R9 echo in reset", {35'b0, echo_clk}, 36'd0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            prev = echo_clk;
            idle();
            chk("R9 echo toggles", {35'b0, echo_clk}, {35'b0, ~prev});
        end

        // R1 R2 full sweep: fill every pair, then read all back
        for (int a = 0; a < (1 << AW); a++)
            wr_burst(AW'(a), pat(2*a, 1), '1, pat(2*a+1, 1), '1);
        for (int a = 0; a < (1 << AW); a++) rd_burst(AW'(a), "sweep");

        // R7 every byte-enable pattern on each beat
        for (int be = 0; be < 16; be++) begin
            wr_burst(6'd50, pat(be, 7), NB'(be), pat(be, 8), ~NB'(be));
            rd_burst(6'd50, "R7 byte mask");
        end

        // R3 deselect with moving inputs
        for (int i = 0; i < 20; i++) begin
            cyc(1'b1, AW'(i), 1'b1, AW'(i), pat(i, 9), '1);
            chk("R3 no read while deselected", {35'b0, rvalid}, 36'd0);
        end
        for (int a = 0; a < 4; a++) rd_burst(AW'(a), "R3 memory untouched");

        // R4 write command during beat 0 ignored
        cyc(1'b1, '0, 1'b0, 6'd10, '0, '1);
        cyc(1'b1, '0, 1'b0, 6'd20, pat(100, 2), '1);
        cyc(1'b1, '0, 1'b1, '0, pat(101, 2), '1);
        model[20] = pat(100, 2);
        model[21] = pat(101, 2);
        idle();
        rd_burst(6'd10, "R4 write kept");
        rd_burst(6'd20, "R4 write not restarted");

        // R4 read command during beat 0 ignored
        cyc(1'b0, 6'd10, 1'b1, '0, '0, '0);
        cyc(1'b0, 6'd20, 1'b1, '0, '0, '0);
        idle();
        chk("R4 read beat0", rdata, model[20]);
        idle();
        chk("R4 read beat1", rdata, model[21]);
        idle();
        chk("R4 read not restarted", {35'b0, rvalid}, 36'd0);

        // R4 back-to-back reads, accepted in the second beat
        cyc(1'b0, 6'd10, 1'b1, '0, '0, '0);
        idle();
        cyc(1'b0, 6'd20, 1'b1, '0, '0, '0);
        chk("R4 b2b a0", rdata, model[20]);
        idle();
        chk("R4 b2b a1", rdata, model[21]);
        idle();
        chk("R4 b2b b0 valid", {35'b0, rvalid}, 36'd1);
        chk("R4 b2b b0", rdata, model[40]);
        idle();
        chk("R4 b2b b1", rdata, model[41]);
        idle();
        chk("R4 b2b end", {35'b0, rvalid}, 36'd0);

        // R4 back-to-back writes
        cyc(1'b1, '0, 1'b0, 6'd30, '0, '0);
        cyc(1'b1, '0, 1'b1, '0, pat(200, 3), '1);
        cyc(1'b1, '0, 1'b0, 6'd31, pat(201, 3), '1);
        cyc(1'b1, '0, 1'b1, '0, pat(202, 3), '1);
        cyc(1'b1, '0, 1'b1, '0, pat(203, 3), '1);
        model[60] = pat(200, 3); model[61] = pat(201, 3);
        model[62] = pat(202, 3); model[63] = pat(203, 3);
        idle();
        rd_burst(6'd30, "R4 b2b write first");
        rd_burst(6'd31, "R4 b2b write second");

        // R8 R5 read one edge after write, same pair: bypass on both beats
        n0 = pat(300, 4); n1 = pat(301, 4);
        cyc(1'b1, '0, 1'b0, 6'd40, '0, '0);
        cyc(1'b0, 6'd40, 1'b1, '0, n0, 4'b0101);
        cyc(1'b1, '0, 1'b1, '0, n1, 4'b1010);
        model[80] = mrg(model[80], n0, 4'b0101);
        model[81] = mrg(model[81], n1, 4'b1010);
        idle();
        chk("R8 bypass beat0", rdata, model[80]);
        idle();
        chk("R8 bypass beat1", rdata, model[81]);
        idle();

        // R8 R5 read and write on the same edge: old contents on both beats
        o0 = model[84]; o1 = model[85];
        n0 = pat(400, 5); n1 = pat(401, 5);
        cyc(1'b0, 6'd42, 1'b0, 6'd42, '0, '0);
        cyc(1'b1, '0, 1'b1, '0, n0, '1);
        cyc(1'b1, '0, 1'b1, '0, n1, '1);
        chk("R8 same edge beat0 old", rdata, o0);
        idle();
        chk("R5 same edge beat1 old", rdata, o1);
        model[84] = n0; model[85] = n1;
        idle();
        rd_burst(6'd42, "R5 write completed");

        finish_run();
    end
endmodule